// File: doc/BRIEF.md
# Sound Chip Bus Write Sequencer

This block turns single-cycle host requests into timed bus cycles for two programmable sound generators. The generators share one convention: an 8-bit multiplexed data bus plus a 3-bit control field made of a reset line and two bus-direction lines. Each generator, called left and right, has its own data bus and control field. A host request carries a command, a chip select, a 4-bit register index and an 8-bit value. There are three commands. A register write runs the address latch and data strobe handshake. A chip reset pulses the reset code and then waits out the recovery time. A clear writes zero to every register of the selected chip.

Every phase has a minimum dwell time. Parameters set each dwell in nanoseconds, and the block converts it to clock cycles from the clock period, rounding up. While an operation runs, `busy` stays high and further requests are dropped. The cycle after the final phase carries a one-cycle `done` pulse and is already idle. A request presented in that cycle is accepted, so operations can run back to back.

Top module: `psg_bus_sequencer`

## Requirements
- R1: With reset held, both control fields read 100 (idle), both data buses read 0, and `busy` and `done` are low.
- R2: Each control field carries {reset, dir, bc} and only takes the codes reset 000, idle 100, data strobe 110 and address latch 111.
- R3: A write (`req_cmd` 00) is accepted at a rising edge where `req_valid` is high and `busy` is low. From the next cycle the chip picked by `req_chip` (0 left, 1 right) shows 111 with the index, zero-extended, on its data bus for ceil(300 ns / period) cycles (38 at 8 ns).
- R4: Next, the control field shows idle with the index still on the bus for ceil(50 ns / period) cycles (7). It then stays idle with the value on the bus for another ceil(50 ns / period) cycles (7).
- R5: Next, the control field shows 110 with the value for ceil(1800 ns / period) cycles (225). Then it shows idle with the value for ceil(100 ns / period) cycles (13).
- R6: A reset (`req_cmd` 01) shows 000 for ceil(500 ns / period) cycles (63), then idle for ceil(5000 ns / period) cycles (625), and leaves the chip's data bus unchanged.
- R7: A clear (`req_cmd` 10) performs 14 writes of value 0 to the selected chip with indices 13, 12, down to 0. Each write uses the timing of R3 to R5, and the writes follow one another with no idle cycle between them.
- R8: While an operation targets one chip, the other chip's control field stays idle and its data bus keeps its value.
- R9: Outside the write phases, a data bus holds the last value driven on it.
- R10: `busy` is high from the cycle after acceptance through the last phase cycle. `done` is high for exactly the one cycle that follows, and `busy` is low in that cycle.
- R11: A request that arrives while `busy` is high is ignored. `req_cmd` 11 is ignored at any time. Neither one changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when idle |
| req_cmd | input | 2 | 00 write, 01 reset, 10 clear, 11 none |
| req_chip | input | 1 | Target chip: 0 left, 1 right |
| req_index | input | 4 | Register index for a write |
| req_value | input | 8 | Register value for a write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| left_ctrl | output | 3 | Left chip {reset, dir, bc} |
| left_data | output | 8 | Left chip data bus |
| right_ctrl | output | 3 | Right chip {reset, dir, bc} |
| right_data | output | 8 | Right chip data bus |

## Verification
The first phase of an operation shows on the ports in the cycle right after the accepting edge. Each later phase starts in the cycle after the previous one's last cycle. `done` falls in the cycle after the final phase cycle. The bench keeps a reference model that expands each accepted request into a queue with one expected entry per cycle. The model takes one entry at every rising edge, and every port is compared against it at the following falling edge, so each phase boundary is checked to the exact cycle. Ignored requests reach the model the same way as real ones: the model drops them while its queue is non-empty, and any extra busy cycle or bus change then shows up as a mismatch.

// File: rtl/psg_seq_pkg.sv
// Package: shared types and helpers for the sound chip bus sequencer.
// Assumes all durations are given in whole nanoseconds and the clock period in picoseconds.
package psg_seq_pkg;

    localparam int NUM_CHIPS = 2;

    // Control field values {reset, dir, bc} driven to a chip.
    typedef enum logic [2:0] {
        CTL_RESET = 3'b000,
        CTL_IDLE  = 3'b100,
        CTL_READ  = 3'b101,
        CTL_WRITE = 3'b110,
        CTL_LATCH = 3'b111
    } bus_ctl_e;

    // Host command encoding.
    typedef enum logic [1:0] {
        CMD_WRITE = 2'b00,
        CMD_RESET = 2'b01,
        CMD_CLEAR = 2'b10,
        CMD_NONE  = 2'b11
    } host_cmd_e;

    // Sequencer phases.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LATCH,
        PH_GAP,
        PH_SETUP,
        PH_STROBE,
        PH_TAIL,
        PH_RPULSE,
        PH_RWAIT
    } seq_phase_e;

    // Converts a duration in ns to clock cycles, rounding up, with a minimum of one.
    function automatic int ns_to_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c < 1) c = 1;
        return c;
    endfunction

    // Returns the larger of two integers.
    function automatic int int_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psg_hold_timer.sv
// Module: down-counting dwell timer shared by all phases.
// A load sets the count to the phase length. expire_o is high in the last cycle of the phase.
// Assumes every load value is at least 1 and TW is at least 2.
module psg_hold_timer #(
    parameter int TW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          expire_o
);

    localparam logic [TW-1:0] CNT_ONE = {{(TW-1){1'b0}}, 1'b1};

    logic [TW-1:0] cnt_q;

    // Count register: a load wins, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign expire_o = (cnt_q == CNT_ONE);

    // R3..R6: without a reload, a running count drops by exactly one per cycle.
    a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

endmodule

// File: rtl/psg_phase_fsm.sv
// Module: operation sequencer. It accepts host requests while idle and steps through
// the write or reset phases, loading the shared timer on each phase change.
// For a clear, it repeats the write phases with indices running from the top register down to 0.
// Assumes every *_C parameter is at least 1 and fits in TW bits.
module psg_phase_fsm
    import psg_seq_pkg::*;
#(
    parameter int TW       = 10,
    parameter int IDXW     = 4,
    parameter int DW       = 8,
    parameter int NUM_REGS = 14,
    parameter int ADDR_C   = 38,
    parameter int GAP_C    = 7,
    parameter int SETUP_C  = 7,
    parameter int STROBE_C = 225,
    parameter int TAIL_C   = 13,
    parameter int RPULSE_C = 63,
    parameter int RWAIT_C  = 625
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid_i,
    input  logic [1:0]      req_cmd_i,
    input  logic            req_chip_i,
    input  logic [IDXW-1:0] req_index_i,
    input  logic [DW-1:0]   req_value_i,
    input  logic            expire_i,
    output logic            load_o,
    output logic [TW-1:0]   load_val_o,
    output seq_phase_e      phase_o,
    output logic            chip_o,
    output logic [IDXW-1:0] index_o,
    output logic [DW-1:0]   value_o,
    output logic            busy_o,
    output logic            done_o
);

    localparam logic [TW-1:0]   ADDR_L   = ADDR_C[TW-1:0];
    localparam logic [TW-1:0]   GAP_L    = GAP_C[TW-1:0];
    localparam logic [TW-1:0]   SETUP_L  = SETUP_C[TW-1:0];
    localparam logic [TW-1:0]   STROBE_L = STROBE_C[TW-1:0];
    localparam logic [TW-1:0]   TAIL_L   = TAIL_C[TW-1:0];
    localparam logic [TW-1:0]   RPULSE_L = RPULSE_C[TW-1:0];
    localparam logic [TW-1:0]   RWAIT_L  = RWAIT_C[TW-1:0];
    localparam int              LAST_I   = NUM_REGS - 1;
    localparam logic [IDXW-1:0] LAST_IDX = LAST_I[IDXW-1:0];
    localparam logic [IDXW-1:0] IDX_ONE  = {{(IDXW-1){1'b0}}, 1'b1};

    seq_phase_e      state_q, state_d;
    logic            chip_q;
    logic            clr_q;
    logic [IDXW-1:0] idx_q;
    logic [DW-1:0]   val_q;
    logic            done_q;
    logic            accept;
    logic            more;
    logic            fin;
    logic            is_clear;

    assign accept   = (state_q == PH_IDLE) && req_valid_i && (req_cmd_i != CMD_NONE);
    assign is_clear = (req_cmd_i == CMD_CLEAR);
    assign more     = clr_q && (idx_q != '0);

    // Next-phase decode and timer reload on every phase change.
    always_comb begin
        state_d    = state_q;
        load_o     = 1'b0;
        load_val_o = '0;
        fin        = 1'b0;
        case (state_q)
            PH_IDLE: begin
                if (accept) begin
                    load_o = 1'b1;
                    if (req_cmd_i == CMD_RESET) begin
                        state_d    = PH_RPULSE;
                        load_val_o = RPULSE_L;
                    end else begin
                        state_d    = PH_LATCH;
                        load_val_o = ADDR_L;
                    end
                end
            end
            PH_LATCH: if (expire_i) begin
                state_d = PH_GAP;    load_o = 1'b1; load_val_o = GAP_L;
            end
            PH_GAP: if (expire_i) begin
                state_d = PH_SETUP;  load_o = 1'b1; load_val_o = SETUP_L;
            end
            PH_SETUP: if (expire_i) begin
                state_d = PH_STROBE; load_o = 1'b1; load_val_o = STROBE_L;
            end
            PH_STROBE: if (expire_i) begin
                state_d = PH_TAIL;   load_o = 1'b1; load_val_o = TAIL_L;
            end
            PH_TAIL: if (expire_i) begin
                if (more) begin
                    state_d = PH_LATCH; load_o = 1'b1; load_val_o = ADDR_L;
                end else begin
                    state_d = PH_IDLE;  fin = 1'b1;
                end
            end
            PH_RPULSE: if (expire_i) begin
                state_d = PH_RWAIT;  load_o = 1'b1; load_val_o = RWAIT_L;
            end
            PH_RWAIT: if (expire_i) begin
                state_d = PH_IDLE;   fin = 1'b1;
            end
            default: state_d = PH_IDLE;
        endcase
    end

    // Phase register and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= fin;
        end
    end

    // Operation registers: captured on acceptance; the index steps down between clear writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chip_q <= 1'b0;
            clr_q  <= 1'b0;
            idx_q  <= '0;
            val_q  <= '0;
        end else if (accept) begin
            chip_q <= req_chip_i;
            clr_q  <= is_clear;
            idx_q  <= is_clear ? LAST_IDX : req_index_i;
            val_q  <= is_clear ? '0 : req_value_i;
        end else if (state_q == PH_TAIL && expire_i && more) begin
            idx_q  <= idx_q - IDX_ONE;
        end
    end

    assign phase_o = state_q;
    assign chip_o  = chip_q;
    assign index_o = idx_q;
    assign value_o = val_q;
    assign busy_o  = (state_q != PH_IDLE);
    assign done_o  = done_q;

    // R10: the completion pulse lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: the completion cycle is already idle.
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R11: a running operation keeps its target and value whatever the host sends.
    a_r11_op_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(chip_q) && $stable(clr_q) && $stable(val_q)));

    // R7: each repeated write of a clear uses the next lower index.
    a_r7_clear_order: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && state_q == PH_LATCH && $past(state_q) == PH_TAIL) |-> (idx_q == $past(idx_q) - IDX_ONE));

endmodule

// File: rtl/psg_chip_port.sv
// Module: per-chip bus driver. It decodes the shared phase into this chip's control code
// and data bus. When this chip is not in a write phase, the bus holds its last value.
// Assumes the index fits in the data width.
module psg_chip_port
    import psg_seq_pkg::*;
#(
    parameter int CHIP_ID = 0,
    parameter int IDXW    = 4,
    parameter int DW      = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  seq_phase_e      phase_i,
    input  logic            sel_i,
    input  logic [IDXW-1:0] index_i,
    input  logic [DW-1:0]   value_i,
    output logic [2:0]      ctrl_o,
    output logic [DW-1:0]   data_o
);

    localparam logic MY_SEL = CHIP_ID[0];

    logic          mine;
    logic          drive;
    logic          addr_phase;
    logic [DW-1:0] hold_q;

    assign mine       = (sel_i == MY_SEL);
    assign addr_phase = (phase_i == PH_LATCH) || (phase_i == PH_GAP);
    assign drive      = mine && (addr_phase || phase_i == PH_SETUP ||
                                 phase_i == PH_STROBE || phase_i == PH_TAIL);

    // Control code decode for this chip.
    always_comb begin
        ctrl_o = CTL_IDLE;
        if (mine) begin
            case (phase_i)
                PH_LATCH:  ctrl_o = CTL_LATCH;
                PH_STROBE: ctrl_o = CTL_WRITE;
                PH_RPULSE: ctrl_o = CTL_RESET;
                default:   ctrl_o = CTL_IDLE;
            endcase
        end
    end

    // Data bus select: index while addressing, value after that, else the held value.
    always_comb begin
        if (!drive)          data_o = hold_q;
        else if (addr_phase) data_o = {{(DW-IDXW){1'b0}}, index_i};
        else                 data_o = value_i;
    end

    // Bus hold register.
    always_ff @(posedge clk) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= data_o;
    end

    // R2: only the four codes the sequence uses ever appear.
    a_r2_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o inside {CTL_RESET, CTL_IDLE, CTL_WRITE, CTL_LATCH});

    // R3: an address latch always follows the idle code.
    a_r3_latch_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o == CTL_LATCH && $past(ctrl_o) != CTL_LATCH) |-> ($past(ctrl_o) == CTL_IDLE));

    // R4: the data bus is already settled when the strobe starts.
    a_r4_data_settled: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o == CTL_WRITE && $past(ctrl_o) != CTL_WRITE) |-> $stable(data_o));

    // R8: a chip that is not targeted sees only the idle code.
    a_r8_other_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mine |-> (ctrl_o == CTL_IDLE));

    // R9: while the sequencer stays idle, the data bus does not move.
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_IDLE && $past(phase_i) == PH_IDLE) |-> $stable(data_o));

endmodule

// File: rtl/psg_bus_sequencer.sv
// Module: top of the sound chip bus write sequencer. It converts the dwell times from ns
// to cycles and connects the sequencer, the shared timer and one bus driver per chip.
// Assumes a single clock with a period of CLK_PERIOD_PS picoseconds.
module psg_bus_sequencer
    import psg_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS  = 8000,
    parameter int ADDR_HOLD_NS   = 300,
    parameter int BUS_GAP_NS     = 50,
    parameter int DATA_SETUP_NS  = 50,
    parameter int STROBE_NS      = 1800,
    parameter int TAIL_NS        = 100,
    parameter int RESET_PULSE_NS = 500,
    parameter int RESET_WAIT_NS  = 5000,
    parameter int NUM_REGS       = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_cmd,
    input  logic       req_chip,
    input  logic [3:0] req_index,
    input  logic [7:0] req_value,
    output logic       busy,
    output logic       done,
    output logic [2:0] left_ctrl,
    output logic [7:0] left_data,
    output logic [2:0] right_ctrl,
    output logic [7:0] right_data
);

    localparam int IDXW     = 4;
    localparam int DW       = 8;
    localparam int ADDR_C   = ns_to_cycles(ADDR_HOLD_NS, CLK_PERIOD_PS);
    localparam int GAP_C    = ns_to_cycles(BUS_GAP_NS, CLK_PERIOD_PS);
    localparam int SETUP_C  = ns_to_cycles(DATA_SETUP_NS, CLK_PERIOD_PS);
    localparam int STROBE_C = ns_to_cycles(STROBE_NS, CLK_PERIOD_PS);
    localparam int TAIL_C   = ns_to_cycles(TAIL_NS, CLK_PERIOD_PS);
    localparam int RPULSE_C = ns_to_cycles(RESET_PULSE_NS, CLK_PERIOD_PS);
    localparam int RWAIT_C  = ns_to_cycles(RESET_WAIT_NS, CLK_PERIOD_PS);
    localparam int MAX_C    = int_max(int_max(int_max(ADDR_C, GAP_C), int_max(SETUP_C, STROBE_C)),
                                      int_max(int_max(TAIL_C, RPULSE_C), RWAIT_C));
    localparam int TW       = int_max(2, $clog2(MAX_C + 1));

    logic            load;
    logic [TW-1:0]   load_val;
    logic            expire;
    seq_phase_e      phase;
    logic            sel_chip;
    logic [IDXW-1:0] cur_index;
    logic [DW-1:0]   cur_value;
    logic [2:0]      ctrl_w [NUM_CHIPS];
    logic [DW-1:0]   data_w [NUM_CHIPS];

    psg_phase_fsm #(
        .TW(TW), .IDXW(IDXW), .DW(DW), .NUM_REGS(NUM_REGS),
        .ADDR_C(ADDR_C), .GAP_C(GAP_C), .SETUP_C(SETUP_C), .STROBE_C(STROBE_C),
        .TAIL_C(TAIL_C), .RPULSE_C(RPULSE_C), .RWAIT_C(RWAIT_C)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_cmd_i(req_cmd), .req_chip_i(req_chip),
        .req_index_i(req_index), .req_value_i(req_value),
        .expire_i(expire), .load_o(load), .load_val_o(load_val),
        .phase_o(phase), .chip_o(sel_chip), .index_o(cur_index), .value_o(cur_value),
        .busy_o(busy), .done_o(done)
    );

    psg_hold_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load_i(load), .load_val_i(load_val), .expire_o(expire)
    );

    for (genvar c = 0; c < NUM_CHIPS; c++) begin : g_port
        psg_chip_port #(.CHIP_ID(c), .IDXW(IDXW), .DW(DW)) u_port (
            .clk(clk), .rst_n(rst_n), .phase_i(phase), .sel_i(sel_chip),
            .index_i(cur_index), .value_i(cur_value),
            .ctrl_o(ctrl_w[c]), .data_o(data_w[c])
        );
    end

    assign left_ctrl  = ctrl_w[0];
    assign left_data  = data_w[0];
    assign right_ctrl = ctrl_w[1];
    assign right_data = data_w[1];

endmodule

// File: tb/psg_bus_sequencer_tb_top.sv
// Bench: a queue-based reference model that is compared with every port on every clock.
module psg_bus_sequencer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_cmd = 2'b11;
    logic       req_chip = 1'b0;
    logic [3:0] req_index = 4'h0;
    logic [7:0] req_value = 8'h00;
    logic       busy, done;
    logic [2:0] left_ctrl, right_ctrl;
    logic [7:0] left_data, right_data;

    psg_bus_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_chip(req_chip), .req_index(req_index), .req_value(req_value),
        .busy(busy), .done(done), .left_ctrl(left_ctrl), .left_data(left_data),
        .right_ctrl(right_ctrl), .right_data(right_data)
    );

    always #4 clk = ~clk;

    function automatic int cyc(input int ns);
        return (ns * 1000 + 7999) / 8000;
    endfunction

    localparam int C_IDLE = 4, C_RST = 0, C_WR = 6, C_LAT = 7;

    int n_checks = 0;
    int n_err = 0;
    bit reported = 1'b0;
    bit live = 1'b0;

    int q[$];
    int op_chip = 0;
    int m_ctrl [2];
    int m_data [2];
    bit m_busy, m_done, m_active;
    int m_tag = 1;

    function automatic string rname(input int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
            5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
            9: return "R9";   10: return "R10"; default: return "R11";
        endcase
    endfunction

    task automatic chk(input int t, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", rname(t), what, act, exp, $time);
        end
    endtask

    task automatic push_n(input int n, input int ctl, input int dat, input int keep, input int dn, input int tag);
        for (int i = 0; i < n; i++)
            q.push_back((tag << 16) | (dn << 13) | (keep << 12) | (ctl << 8) | dat);
    endtask

    // One register write: R3 latch, R4 gap and setup, R5 strobe and tail (all tagged R7 in a clear).
    task automatic push_write(input int idx, input int val, input bit clr);
        push_n(cyc(300),  C_LAT,  idx, 0, 0, clr ? 7 : 3);
        push_n(cyc(50),   C_IDLE, idx, 0, 0, clr ? 7 : 4);
        push_n(cyc(50),   C_IDLE, val, 0, 0, clr ? 7 : 4);
        push_n(cyc(1800), C_WR,   val, 0, 0, clr ? 7 : 5);
        push_n(cyc(100),  C_IDLE, val, 0, 0, clr ? 7 : 5);
    endtask

    // Reference model: expected port values for the cycle after each rising edge.
    always @(posedge clk) begin
        int e;
        if (!rst_n) begin
            q.delete();
            for (int c = 0; c < 2; c++) begin m_ctrl[c] = C_IDLE; m_data[c] = 0; end
            m_busy = 0; m_done = 0; m_active = 0; m_tag = 1; live = 1'b1;
        end else begin
            if (q.size() == 0 && req_valid && req_cmd != 2'b11) begin
                op_chip = int'(req_chip);
                case (req_cmd)
                    2'b00: push_write(int'(req_index), int'(req_value), 1'b0);
                    2'b01: begin
                        push_n(cyc(500),  C_RST,  0, 1, 0, 6);
                        push_n(cyc(5000), C_IDLE, 0, 1, 0, 6);
                    end
                    default: for (int i = 13; i >= 0; i--) push_write(i, 0, 1'b1);
                endcase
                push_n(1, C_IDLE, 0, 1, 1, 10);
            end
            m_ctrl[0] = C_IDLE; m_ctrl[1] = C_IDLE;
            if (q.size() > 0) begin
                e = q.pop_front();
                m_tag = (e >> 16) & 255;
                m_done = e[13];
                m_busy = !e[13];
                m_active = 1;
                m_ctrl[op_chip] = (e >> 8) & 7;
                if (!e[12]) m_data[op_chip] = e & 255;
            end else begin
                m_busy = 0; m_done = 0; m_active = 0; m_tag = 9;
            end
        end
    end

    // Comparison away from the active edge.
    always @(negedge clk) begin
        logic [2:0] ac [2];
        logic [7:0] ad [2];
        int tg;
        if (live) begin
            ac[0] = left_ctrl;  ad[0] = left_data;
            ac[1] = right_ctrl; ad[1] = right_data;
            for (int c = 0; c < 2; c++) begin
                if (m_tag == 1) tg = 1;
                else if (m_active && c == op_chip) tg = m_tag;
                else if (m_active) tg = 8;
                else tg = 9;
                chk(tg, c == 0 ? "left_ctrl" : "right_ctrl", 32'(ac[c]), 32'(m_ctrl[c]));
                chk(tg, c == 0 ? "left_data" : "right_data", 32'(ad[c]), 32'(m_data[c]));
                // R2: only codes 000, 100, 110, 111 are legal
                chk(2, "ctrl code legal",
                    32'(ac[c] === 3'b000 || ac[c] === 3'b100 || ac[c] === 3'b110 || ac[c] === 3'b111), 32'd1);
            end
            chk(m_tag == 1 ? 1 : (m_active ? 10 : 11), "busy", 32'(busy), 32'(m_busy));
            chk(m_tag == 1 ? 1 : 10, "done", 32'(done), 32'(m_done));
        end
    end

    task automatic issue(input logic [1:0] cmd, input logic chip, input logic [3:0] idx, input logic [7:0] val);
        req_valid = 1'b1; req_cmd = cmd; req_chip = chip; req_index = idx; req_value = val;
        @(negedge clk);
        req_valid = 1'b0; req_cmd = 2'b11;
    endtask

    task automatic wait_done;
        do @(negedge clk); while (done !== 1'b1);
    endtask

    task automatic finish_run;
        if (!reported) begin
            reported = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        finish_run();
    end

    // Stimulus.
    initial begin
        repeat (3) @(negedge clk);              // R1 reset state checked by the model
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        issue(2'b00, 1'b0, 4'd4, 8'h51);        // R3 R4 R5 write to left
        repeat (10) @(negedge clk);
        issue(2'b00, 1'b1, 4'd9, 8'hAA);        // R11 ignored while busy
        wait_done();
        issue(2'b00, 1'b1, 4'd7, 8'h38);        // R8 right write, left holds 0x51
        wait_done();
        issue(2'b00, 1'b1, 4'd10, 8'h0C);       // R10 back to back in the done cycle
        wait_done();
        repeat (5) @(negedge clk);              // R9 hold while idle
        issue(2'b11, 1'b0, 4'd2, 8'hFF);        // R11 command 11 ignored
        repeat (5) @(negedge clk);
        issue(2'b01, 1'b1, 4'd0, 8'h00);        // R6 reset right, data stays 0x0C
        wait_done();
        issue(2'b10, 1'b0, 4'd5, 8'h77);        // R7 clear left, 13 down to 0
        wait_done();
        repeat (8) @(negedge clk);
        finish_run();
    end

endmodule